// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recently used page-table entries and turns a 32-bit virtual address into a 32-bit physical address. Pages are 4 KB, so the upper 20 bits form the virtual page number and the lower 12 bits pass through unchanged as the page offset. A lookup compares the page number against every valid slot in parallel. The result is registered and appears one cycle after the request as a hit, a miss or a protection fault. On a hit the block returns the stored frame number joined with the offset, together with the entry's permission and modified bits.

After a miss, an external table walker fetches the page-table entry and writes it back through the refill port. If the entry's present bit is clear, the block raises a page fault and installs nothing. Each slot holds modified, writable and kernel-only bits next to the frame number. The first write that hits a clean page marks that slot modified and pulses a write-back request. A single flush command empties the whole buffer when the running process changes.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every slot is empty and all result outputs (`hit_o`, `miss_o`, `prot_fault_o`, `page_fault_o`, `wb_req_o`) are low.
- R2: A lookup whose page number matches a valid slot and passes the permission checks sets `hit_o` in the next cycle. In that cycle `paddr_o` equals {stored frame, vaddr_i[11:0]}, and `pte_writable_o` and `pte_kernel_o` show the slot's bits.
- R3: A lookup whose page number matches no valid slot sets `miss_o` in the next cycle and leaves `hit_o` low.
- R4: A refill with `fill_present_i` = 1 installs the entry, and later lookups of that page number hit with the refilled frame.
- R5: A refill with `fill_present_i` = 0 sets `page_fault_o` in the next cycle and installs nothing, so a later lookup of that page still misses.
- R6: A refill of a new page goes to the lowest-numbered empty slot. When every slot is full, it goes to a victim pointer that starts at slot 0 after reset or flush and moves forward by one after each replacement.
- R7: A refill whose page number is already held overwrites that slot in place, and no second copy is created.
- R8: A write lookup (`write_i` = 1) that hits a slot whose writable bit is 0 sets `prot_fault_o` and leaves `hit_o` low.
- R9: A user-mode lookup (`user_i` = 1) that hits a slot whose kernel bit is 1 sets `prot_fault_o` and leaves `hit_o` low.
- R10: A permitted write hit on a slot whose modified bit is 0 sets that bit and pulses `wb_req_o` with the hit. Later write hits on the same slot do not pulse `wb_req_o`. `pte_modified_o` reads 1 in both cases.
- R11: `flush_i` empties every slot, and it overrides a refill presented in the same cycle.
- R12: A lookup and a refill presented in the same cycle see the contents as they were before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| vaddr_i | input | 32 | Virtual address to translate |
| write_i | input | 1 | Lookup is a write access |
| user_i | input | 1 | Lookup comes from user mode |
| hit_o | output | 1 | Translation succeeded |
| miss_o | output | 1 | Page not held; walker must refill |
| prot_fault_o | output | 1 | Permission violation on a held page |
| paddr_o | output | 32 | Translated physical address |
| pte_writable_o | output | 1 | Writable bit of the accessed slot |
| pte_kernel_o | output | 1 | Kernel-only bit of the accessed slot |
| pte_modified_o | output | 1 | Modified bit of the slot after this access |
| wb_req_o | output | 1 | First write to a clean page |
| fill_valid_i | input | 1 | Refill strobe from walker |
| fill_vpn_i | input | 20 | Page number being refilled |
| fill_present_i | input | 1 | Fetched entry is resident |
| fill_modified_i | input | 1 | Fetched modified bit |
| fill_writable_i | input | 1 | Fetched writable bit |
| fill_kernel_i | input | 1 | Fetched kernel-only bit |
| fill_frame_i | input | 20 | Fetched frame number |
| page_fault_o | output | 1 | Refill had present bit clear |
| flush_i | input | 1 | Invalidate all slots |

## Verification
A corrupted valid bit or page-number store shows up on the very next lookup of that page, as a wrong miss or a wrong hit. A victim pointer that is off by one only becomes visible after the buffer fills up: a replacement then evicts the wrong page, and the error shows in the lookup that follows that refill. Because `pte_modified_o` and `wb_req_o` come out with each hit, a modified bit that was not kept shows up on the second write to the same page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 12;
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PFN_W     = 20;
  localparam int PA_W      = PFN_W + PAGE_BITS;

  typedef struct packed {
    logic             modified;
    logic             writable;
    logic             kernel;
    logic [PFN_W-1:0] frame;
  } pte_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 8,
  parameter int KEY_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [KEY_W-1:0]        key_i,
  input  logic [N-1:0][KEY_W-1:0] tags_i,
  input  logic [N-1:0]            valid_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (eq[i]) idx_o = IDX_W'(i);
  end

  assign hit_o = |eq;

  // R7
  always_comb match_unique_chk: assert ($onehot0(eq) || $isunknown(eq));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             adv_i,
  input  logic             clear_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
  end

  assign victim_o = any_free ? free_idx : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (adv_i)   ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R6
  property adv_only_full_p;
    @(posedge clk_i) disable iff (!rst_ni) adv_i |-> (&valid_i);
  endproperty
  adv_only_full_chk: assert property (adv_only_full_p);

  // R6
  property ptr_steps_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !clear_i && ptr_q != IDX_W'(N - 1)) |=> ptr_q == $past(ptr_q) + 1'b1;
  endproperty
  ptr_steps_chk: assert property (ptr_steps_p);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_valid_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             write_i,
  input  logic             user_i,
  output logic             hit_o,
  output logic             miss_o,
  output logic             prot_fault_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             pte_writable_o,
  output logic             pte_kernel_o,
  output logic             pte_modified_o,
  output logic             wb_req_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic             fill_present_i,
  input  logic             fill_modified_i,
  input  logic             fill_writable_i,
  input  logic             fill_kernel_i,
  input  logic [PFN_W-1:0] fill_frame_i,
  output logic             page_fault_o,
  input  logic             flush_i
);
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  pte_t [ENTRIES-1:0]            pte_q;

  logic             lk_hit, fl_hit;
  logic [IDX_W-1:0] lk_idx, fl_idx, vic_idx, fill_idx;
  pte_t             sel;
  logic             perm_bad, look_ok, look_bad, set_mod, install, adv;

  tlb_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_look (
    .key_i(vaddr_i[VA_W-1:PAGE_BITS]), .tags_i(vpn_q), .valid_i(valid_q),
    .hit_o(lk_hit), .idx_o(lk_idx)
  );

  tlb_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_fill (
    .key_i(fill_vpn_i), .tags_i(vpn_q), .valid_i(valid_q),
    .hit_o(fl_hit), .idx_o(fl_idx)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk_i, .rst_ni, .valid_i(valid_q), .adv_i(adv), .clear_i(flush_i),
    .victim_o(vic_idx)
  );

  assign sel      = pte_q[lk_idx];
  assign perm_bad = (write_i && !sel.writable) || (user_i && sel.kernel);
  assign look_ok  = lookup_valid_i && lk_hit && !perm_bad;
  assign look_bad = lookup_valid_i && lk_hit && perm_bad;
  assign set_mod  = look_ok && write_i && !sel.modified;
  assign install  = fill_valid_i && fill_present_i && !flush_i;
  assign fill_idx = fl_hit ? fl_idx : vic_idx;
  assign adv      = install && !fl_hit && (&valid_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      vpn_q   <= '0;
      pte_q   <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else begin
      if (set_mod) pte_q[lk_idx].modified <= 1'b1;
      if (install) begin                       // refill wins over same-slot update
        valid_q[fill_idx] <= 1'b1;
        vpn_q[fill_idx]   <= fill_vpn_i;
        pte_q[fill_idx]   <= '{modified: fill_modified_i, writable: fill_writable_i,
                               kernel: fill_kernel_i, frame: fill_frame_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= 1'b0; miss_o <= 1'b0; prot_fault_o <= 1'b0; paddr_o <= '0;
      pte_writable_o <= 1'b0; pte_kernel_o <= 1'b0; pte_modified_o <= 1'b0;
      wb_req_o <= 1'b0; page_fault_o <= 1'b0;
    end else begin
      hit_o          <= look_ok;
      miss_o         <= lookup_valid_i && !lk_hit;
      prot_fault_o   <= look_bad;
      paddr_o        <= look_ok ? {sel.frame, vaddr_i[PAGE_BITS-1:0]} : '0;
      pte_writable_o <= (look_ok || look_bad) && sel.writable;
      pte_kernel_o   <= (look_ok || look_bad) && sel.kernel;
      pte_modified_o <= (look_ok || look_bad) && (sel.modified || set_mod);
      wb_req_o       <= set_mod;
      page_fault_o   <= fill_valid_i && !fill_present_i && !flush_i;
    end
  end

  // R2
  property one_result_p;
    @(posedge clk_i) disable iff (!rst_ni) $onehot0({hit_o, miss_o, prot_fault_o});
  endproperty
  one_result_chk: assert property (one_result_p);

  // R3
  property lookup_answers_p;
    @(posedge clk_i) disable iff (!rst_ni) lookup_valid_i |=> (hit_o || miss_o || prot_fault_o);
  endproperty
  lookup_answers_chk: assert property (lookup_answers_p);

  // R2
  property offset_kept_p;
    @(posedge clk_i) disable iff (!rst_ni)
      lookup_valid_i |=> (!hit_o || paddr_o[PAGE_BITS-1:0] == $past(vaddr_i[PAGE_BITS-1:0]));
  endproperty
  offset_kept_chk: assert property (offset_kept_p);

  // R5
  property no_install_on_fault_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (fill_valid_i && !fill_present_i && !flush_i && !fl_hit) |=> valid_q == $past(valid_q);
  endproperty
  no_install_on_fault_chk: assert property (no_install_on_fault_p);

  // R10
  property wb_needs_write_hit_p;
    @(posedge clk_i) disable iff (!rst_ni) wb_req_o |-> (hit_o && pte_modified_o && pte_writable_o);
  endproperty
  wb_needs_write_hit_chk: assert property (wb_needs_write_hit_p);

  // R11
  property flush_empties_p;
    @(posedge clk_i) disable iff (!rst_ni) flush_i |=> valid_q == '0;
  endproperty
  flush_empties_chk: assert property (flush_empties_p);

  // R8
  property ro_write_blocked_p;
    @(posedge clk_i) disable iff (!rst_ni) (hit_o && !pte_writable_o) |-> !wb_req_o;
  endproperty
  ro_write_blocked_chk: assert property (ro_write_blocked_p);
endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lookup_valid = 0, write = 0, user = 0;
  logic [31:0] vaddr = '0;
  logic        hit, miss, prot, pw, pk, pm, wb, pf;
  logic [31:0] paddr;
  logic        fill_valid = 0, fill_present = 0, fill_mod = 0, fill_wr = 0, fill_kern = 0;
  logic [19:0] fill_vpn = '0, fill_frame = '0;
  logic        flush = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk_i(clk), .rst_ni(rst_n), .lookup_valid_i(lookup_valid), .vaddr_i(vaddr),
    .write_i(write), .user_i(user), .hit_o(hit), .miss_o(miss), .prot_fault_o(prot),
    .paddr_o(paddr), .pte_writable_o(pw), .pte_kernel_o(pk), .pte_modified_o(pm),
    .wb_req_o(wb), .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn),
    .fill_present_i(fill_present), .fill_modified_i(fill_mod), .fill_writable_i(fill_wr),
    .fill_kernel_i(fill_kern), .fill_frame_i(fill_frame), .page_fault_o(pf), .flush_i(flush)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one-cycle stimulus; outputs are read at the following negedge
  task automatic cycle(input logic lv, input logic [31:0] va, input logic w, input logic u,
                       input logic fv, input logic [19:0] vpn, input logic p, input logic m,
                       input logic fw, input logic fk, input logic [19:0] fr, input logic fl);
    @(negedge clk);
    lookup_valid = lv; vaddr = va; write = w; user = u;
    fill_valid = fv; fill_vpn = vpn; fill_present = p; fill_mod = m;
    fill_wr = fw; fill_kern = fk; fill_frame = fr; flush = fl;
    @(negedge clk);
    lookup_valid = 0; fill_valid = 0; flush = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic w, input logic u);
    cycle(1, va, w, u, 0, '0, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic p, input logic m, input logic fw,
                      input logic fk, input logic [19:0] fr);
    cycle(0, '0, 0, 0, 1, vpn, p, m, fw, fk, fr, 0);
  endtask

  task automatic do_flush();
    cycle(0, '0, 0, 0, 0, '0, 0, 0, 0, 0, '0, 1);
  endtask

  task automatic t_reset();
    chk("R1 hit", hit, 0); chk("R1 miss", miss, 0); chk("R1 prot", prot, 0);
    chk("R1 pf", pf, 0); chk("R1 wb", wb, 0);
    look(32'h0000_5000, 0, 0);
    chk("R1 empty miss", miss, 1); chk("R3 no hit", hit, 0);
  endtask

  task automatic t_fill_hit();
    fill(20'h12345, 1, 0, 1, 0, 20'hABCDE);
    chk("R4 no pf", pf, 0);
    look(32'h1234_5678, 0, 1);
    chk("R2 hit", hit, 1); chk("R2 paddr", paddr, 32'hABCD_E678);
    chk("R2 writable", pw, 1); chk("R2 kernel", pk, 0); chk("R3 no miss", miss, 0);
  endtask

  task automatic t_page_fault();
    fill(20'h00077, 0, 0, 1, 0, 20'h00001);
    chk("R5 pf", pf, 1);
    look(32'h0007_7000, 0, 0);
    chk("R5 not installed", miss, 1);
    chk("R5 pf clears", pf, 0);
  endtask

  task automatic t_prot();
    fill(20'h00100, 1, 0, 0, 0, 20'h00200);
    look(32'h0010_0004, 1, 1);
    chk("R8 prot", prot, 1); chk("R8 no hit", hit, 0); chk("R8 no wb", wb, 0);
    look(32'h0010_0004, 0, 1);
    chk("R8 read ok", hit, 1);
    fill(20'h00200, 1, 0, 1, 1, 20'h00300);
    look(32'h0020_0010, 0, 1);
    chk("R9 prot", prot, 1); chk("R9 no hit", hit, 0);
    look(32'h0020_0010, 0, 0);
    chk("R9 kernel ok", hit, 1); chk("R9 paddr", paddr, 32'h0030_0010);
  endtask

  task automatic t_modify();
    look(32'h1234_5000, 1, 0);
    chk("R10 hit", hit, 1); chk("R10 wb", wb, 1); chk("R10 mod", pm, 1);
    look(32'h1234_5004, 1, 0);
    chk("R10 second wb", wb, 0); chk("R10 mod kept", pm, 1);
  endtask

  task automatic t_overwrite();
    fill(20'h12345, 1, 0, 1, 0, 20'h11111);
    look(32'h1234_5abc, 0, 0);
    chk("R7 new frame", paddr, 32'h1111_1abc);
    chk("R7 mod reloaded", pm, 0);
  endtask

  task automatic t_replace();
    do_flush();
    look(32'h1234_5000, 0, 0);
    chk("R11 flushed", miss, 1);
    for (int i = 0; i < 8; i++) fill(20'h40 + 20'(i), 1, 0, 1, 0, 20'h100 + 20'(i));
    look(32'h0004_7000, 0, 0);
    chk("R6 eighth held", paddr, 32'h0010_7000);
    fill(20'h48, 1, 0, 1, 0, 20'h200);
    look(32'h0004_0000, 0, 0);
    chk("R6 slot0 evicted", miss, 1);
    look(32'h0004_1000, 0, 0);
    chk("R6 slot1 kept", hit, 1);
    look(32'h0004_8000, 0, 0);
    chk("R6 new frame", paddr, 32'h0020_0000);
    fill(20'h49, 1, 0, 1, 0, 20'h201);
    look(32'h0004_1000, 0, 0);
    chk("R6 slot1 evicted", miss, 1);
    look(32'h0004_2000, 0, 0);
    chk("R6 slot2 kept", hit, 1);
  endtask

  task automatic t_flush_prio();
    cycle(0, '0, 0, 0, 1, 20'h00055, 1, 0, 1, 0, 20'h00555, 1);
    look(32'h0005_5000, 0, 0);
    chk("R11 fill dropped", miss, 1);
    look(32'h0004_3000, 0, 0);
    chk("R11 all empty", miss, 1);
  endtask

  task automatic t_same_cycle();
    cycle(1, 32'h0006_6000, 0, 0, 1, 20'h00066, 1, 0, 1, 0, 20'h00666, 0);
    chk("R12 old view", miss, 1);
    look(32'h0006_6123, 0, 0);
    chk("R12 then hit", paddr, 32'h0066_6123);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_hit();
    t_page_fault();
    t_prot();
    t_modify();
    t_overwrite();
    t_replace();
    t_flush_prio();
    t_same_cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule